// File: doc/BRIEF.md
# Three-Channel Match Timer with Captured Count Readout

This block holds a small set of free-running up-counters behind a simple word-addressed register bus. Each channel has its own run bit, several compare registers, a reload value and a reload-select mask. When a channel's count equals one of its compare registers, a sticky status flag is set. If that comparator is chosen in the reload-select mask, the count also restarts from the reload value instead of stepping on. Status flags gated by per-flag enables form one interrupt line per channel.

Software does not read a live count. It writes a request to the capture register and waits a fixed four clock cycles. It then reads back a frozen copy of one channel's count. The channel is named by a select register. While a capture is pending, a busy flag is raised. A read during that time returns the previous capture, and a further request is dropped.

Top module: `mtmr_top`

## Requirements
- R1: After a synchronous reset, every count, run bit, status flag, interrupt enable, reload value, reload mask, channel select and the busy flag read 0, and every compare register reads 0xFFFFFFFF.
- R2: Bit c of the run register (global offset 0) lets channel c count. While the bit is 0, that channel's count keeps its value.
- R3: A running channel with no reload in effect adds 1 to its count on each clock. From 0xFFFFFFFF it steps to 0.
- R4: When a running channel's count equals compare register k, status bit k of that channel is set on the next edge. It stays set until it is cleared.
- R5: When compare k hits and bit k of the channel's reload mask is 1, the next count is the reload value instead of count+1.
- R6: Writing to a channel's clear offset clears each status bit whose data bit is 1. A hit on that bit in the same cycle wins and leaves it set.
- R7: irq[c] is 1 exactly when channel c has some status bit k that is set while its interrupt-enable bit k is also set.
- R8: Writing data bit 0 = 1 to the capture register (global offset 2) while idle raises busy (global offset 3, bit 0) after that edge. Busy stays high for 4 cycles. On the 4th edge the count of the channel named by the select register at request time (global offset 1) is latched. A select value of 3 latches 0.
- R9: While busy is high, a read of the capture register returns the previous capture, and a new request has no effect.
- R10: Address map: bits [4:3] = 0 is the global group, and bits [4:3] = c+1 is channel c. In a channel, offsets 0..2 are compare 0..2, 3 is the reload value, 4 is the reload mask, 5 is status (read only), 6 is interrupt enable and 7 is clear (reads 0). Unused global offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 3 | Per-channel interrupt |

## Verification
The hardest case to reach is a compare hit that lands in the same cycle as a clear write or a capture edge. The counts run on their own, so the bench cannot simply steer them into such a cycle. The random stimulus keeps compare and reload values small, so that reloads make the counts cycle often and hits land at many phases against clear writes and capture edges. Periodic resets keep the counts in that range. A bench model tracks every edge, and each random read is compared with it. Directed steps cover the busy window one edge at a time and the step of the count from 0xFFFFFFFF to 0, which the bench reaches by loading a reload value just below the top.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
package mtmr_pkg;
    localparam int NUM_CH   = 3;
    localparam int NUM_CMP  = 3;
    localparam int CNT_W    = 32;
    localparam int SNAP_DLY = 4;
    localparam int OFS_W    = 3;
    localparam int GRP_W    = $clog2(NUM_CH + 1);
    localparam int ADDR_W   = GRP_W + OFS_W;
    localparam int SEL_W    = $clog2(NUM_CH + 1);
    localparam int PH_W     = $clog2(SNAP_DLY);

    typedef enum logic [OFS_W-1:0] {
        G_RUN  = 3'd0,
        G_SEL  = 3'd1,
        G_SNAP = 3'd2,
        G_BUSY = 3'd3
    } glob_ofs_e;

    typedef enum logic [OFS_W-1:0] {
        C_PRE  = 3'd3,
        C_MASK = 3'd4,
        C_STAT = 3'd5,
        C_IE   = 3'd6,
        C_CLR  = 3'd7
    } chan_ofs_e;

    typedef struct packed {
        logic [NUM_CMP-1:0] cmp;
        logic               pre;
        logic               mask;
        logic               ie;
        logic               clr;
    } chan_wr_t;

    typedef struct packed {
        logic             busy;
        logic [PH_W-1:0]  phase;
        logic [SEL_W-1:0] chan;
    } snap_state_t;

    function automatic logic [GRP_W-1:0] grp_of(input int ch);
        return GRP_W'(ch + 1);
    endfunction
endpackage

// File: rtl/mtmr_chan.sv
`timescale 1ns/1ps
module mtmr_chan
    import mtmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run,
    input  chan_wr_t                      wr,
    input  logic [CW-1:0]                 wdata,
    output logic [CW-1:0]                 count,
    output logic [NUM_CMP-1:0][CW-1:0]    cmp_val,
    output logic [CW-1:0]                 pre_val,
    output logic [NUM_CMP-1:0]            mask,
    output logic [NUM_CMP-1:0]            stat,
    output logic [NUM_CMP-1:0]            ie,
    output logic                          irq
);
    logic [NUM_CMP-1:0] hit;
    logic               reload;
    logic [NUM_CMP-1:0] clr_bits;

    always_comb begin
        for (int k = 0; k < NUM_CMP; k++)
            hit[k] = run && (count == cmp_val[k]);
    end

    assign reload   = |(hit & mask);
    assign clr_bits = wr.clr ? wdata[NUM_CMP-1:0] : '0;
    assign irq      = |(stat & ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            cmp_val <= '1;
            pre_val <= '0;
            mask    <= '0;
            stat    <= '0;
            ie      <= '0;
        end else begin
            if (run)
                count <= reload ? pre_val : count + 1'b1;
            for (int k = 0; k < NUM_CMP; k++)
                if (wr.cmp[k]) cmp_val[k] <= wdata;
            if (wr.pre)  pre_val <= wdata;
            if (wr.mask) mask    <= wdata[NUM_CMP-1:0];
            if (wr.ie)   ie      <= wdata[NUM_CMP-1:0];
            stat <= (stat & ~clr_bits) | hit;
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !reload) |=> count == $past(count) + 1'b1);
    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr.clr |=> (stat & $past(stat)) == $past(stat));
    // R6
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.clr && !run) |=> (stat & $past(wdata[NUM_CMP-1:0])) == '0);
endmodule

// File: rtl/mtmr_snap.sv
`timescale 1ns/1ps
module mtmr_snap
    import mtmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NCH = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [SEL_W-1:0]       sel,
    input  logic [NCH-1:0][CW-1:0] counts,
    output logic                   busy,
    output logic [CW-1:0]          snap
);
    snap_state_t st;
    logic        last;
    logic [CW-1:0] picked;

    assign busy = st.busy;
    assign last = st.busy && (st.phase == PH_W'(SNAP_DLY - 1));

    always_comb begin
        picked = '0;
        for (int c = 0; c < NCH; c++)
            if (st.chan == SEL_W'(c)) picked = counts[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            snap <= '0;
        end else if (st.busy) begin
            if (last) begin
                snap    <= picked;
                st.busy <= 1'b0;
            end else begin
                st.phase <= st.phase + 1'b1;
            end
        end else if (req) begin
            st.busy  <= 1'b1;
            st.phase <= '0;
            st.chan  <= sel;
        end
    end

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(snap));
endmodule

// File: rtl/mtmr_top.sv
`timescale 1ns/1ps
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int NCH = NUM_CH,
    localparam int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] irq
);
    logic [GRP_W-1:0] grp;
    logic [OFS_W-1:0] ofs;
    assign grp = bus_addr[AW-1:OFS_W];
    assign ofs = bus_addr[OFS_W-1:0];

    logic [NCH-1:0]   run_q;
    logic [SEL_W-1:0] sel_q;
    logic             snap_busy;
    logic [CW-1:0]    snap_val;
    logic             glob_we;
    logic             snap_req;

    assign glob_we  = bus_we && (grp == '0);
    assign snap_req = glob_we && (ofs == G_SNAP) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            sel_q <= '0;
        end else if (glob_we) begin
            if (ofs == G_RUN) run_q <= bus_wdata[NCH-1:0];
            if (ofs == G_SEL) sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    logic [NCH-1:0][CW-1:0]              cnt_vec;
    logic [NCH-1:0][NUM_CMP-1:0][CW-1:0] cmp_vec;
    logic [NCH-1:0][CW-1:0]              pre_vec;
    logic [NCH-1:0][NUM_CMP-1:0]         mask_vec;
    logic [NCH-1:0][NUM_CMP-1:0]         stat_vec;
    logic [NCH-1:0][NUM_CMP-1:0]         ie_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_wr_t wr;
        logic     hit_grp;
        assign hit_grp = bus_we && (grp == grp_of(c));
        always_comb begin
            for (int k = 0; k < NUM_CMP; k++)
                wr.cmp[k] = hit_grp && (ofs == OFS_W'(k));
            wr.pre  = hit_grp && (ofs == C_PRE);
            wr.mask = hit_grp && (ofs == C_MASK);
            wr.ie   = hit_grp && (ofs == C_IE);
            wr.clr  = hit_grp && (ofs == C_CLR);
        end

        mtmr_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .run     (run_q[c]),
            .wr      (wr),
            .wdata   (bus_wdata),
            .count   (cnt_vec[c]),
            .cmp_val (cmp_vec[c]),
            .pre_val (pre_vec[c]),
            .mask    (mask_vec[c]),
            .stat    (stat_vec[c]),
            .ie      (ie_vec[c]),
            .irq     (irq[c])
        );
    end

    mtmr_snap #(.CW(CW), .NCH(NCH)) u_snap (
        .clk    (clk),
        .rst    (rst),
        .req    (snap_req),
        .sel    (sel_q),
        .counts (cnt_vec),
        .busy   (snap_busy),
        .snap   (snap_val)
    );

    always_comb begin
        bus_rdata = '0;
        if (grp == '0) begin
            case (ofs)
                G_RUN:   bus_rdata = CW'(run_q);
                G_SEL:   bus_rdata = CW'(sel_q);
                G_SNAP:  bus_rdata = snap_val;
                G_BUSY:  bus_rdata = CW'(snap_busy);
                default: bus_rdata = '0;
            endcase
        end
        for (int c = 0; c < NCH; c++) begin
            if (grp == grp_of(c)) begin
                for (int k = 0; k < NUM_CMP; k++)
                    if (ofs == OFS_W'(k)) bus_rdata = cmp_vec[c][k];
                if (ofs == C_PRE)  bus_rdata = pre_vec[c];
                if (ofs == C_MASK) bus_rdata = CW'(mask_vec[c]);
                if (ofs == C_STAT) bus_rdata = CW'(stat_vec[c]);
                if (ofs == C_IE)   bus_rdata = CW'(ie_vec[c]);
            end
        end
    end

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        (irq == '0) || (stat_vec != '0));
endmodule

// File: tb/mtmr_top_test.sv
`timescale 1ns/1ps
module mtmr_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mtmr_top uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model, updated from the requirements at every edge
    logic [31:0] m_cnt [3];
    logic [31:0] m_cmp [3][3];
    logic [31:0] m_pre [3];
    logic [2:0]  m_mask[3];
    logic [2:0]  m_stat[3];
    logic [2:0]  m_ie  [3];
    logic [2:0]  m_run;
    logic [1:0]  m_sel;
    logic        m_busy;
    int          m_ph;
    logic [1:0]  m_chan;
    logic [31:0] m_snap;

    always @(posedge clk) begin
        logic [2:0] h;
        logic [1:0] g;
        logic [2:0] o;
        g = bus_addr[4:3];
        o = bus_addr[2:0];
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = 0; m_pre[c] = 0; m_mask[c] = 0; m_stat[c] = 0; m_ie[c] = 0;
                for (int k = 0; k < 3; k++) m_cmp[c][k] = 32'hFFFF_FFFF;
            end
            m_run = 0; m_sel = 0; m_busy = 0; m_ph = 0; m_chan = 0; m_snap = 0;
        end else begin
            if (m_busy) begin
                if (m_ph == 3) begin
                    m_snap = (m_chan < 3) ? m_cnt[m_chan] : 32'd0;
                    m_busy = 0;
                end else m_ph++;
            end else if (bus_we && g == 0 && o == 2 && bus_wdata[0]) begin
                m_busy = 1; m_ph = 0; m_chan = m_sel;
            end
            for (int c = 0; c < 3; c++) begin
                for (int k = 0; k < 3; k++) h[k] = m_run[c] && (m_cnt[c] == m_cmp[c][k]);
                if (m_run[c]) m_cnt[c] = (|(h & m_mask[c])) ? m_pre[c] : m_cnt[c] + 1;
                if (bus_we && g == 2'(c + 1) && o == 7) m_stat[c] = m_stat[c] & ~bus_wdata[2:0];
                m_stat[c] = m_stat[c] | h;
                if (bus_we && g == 2'(c + 1)) begin
                    if (o < 3)  m_cmp[c][o] = bus_wdata;
                    if (o == 3) m_pre[c]  = bus_wdata;
                    if (o == 4) m_mask[c] = bus_wdata[2:0];
                    if (o == 6) m_ie[c]   = bus_wdata[2:0];
                end
            end
            if (bus_we && g == 0 && o == 0) m_run = bus_wdata[2:0];
            if (bus_we && g == 0 && o == 1) m_sel = bus_wdata[1:0];
        end
    end

    function automatic logic [31:0] model_rd(input logic [4:0] a);
        logic [1:0] g = a[4:3];
        logic [2:0] o = a[2:0];
        if (g == 0) begin
            case (o)
                0: return 32'(m_run);
                1: return 32'(m_sel);
                2: return m_snap;
                3: return 32'(m_busy);
                default: return 0;
            endcase
        end
        if (o < 3)  return m_cmp[g-1][o];
        if (o == 3) return m_pre[g-1];
        if (o == 4) return 32'(m_mask[g-1]);
        if (o == 5) return 32'(m_stat[g-1]);
        if (o == 6) return 32'(m_ie[g-1]);
        return 0;
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] r;
        for (int c = 0; c < 3; c++) r[c] = |(m_stat[c] & m_ie[c]);
        return r;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[4:3] == 0) return (a[2:0] == 2 || a[2:0] == 3) ? "R8/R9" : "R2/R10";
        if (a[2:0] == 5) return "R4/R5/R6";
        if (a[2:0] == 7) return "R10";
        return "R3/R10";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // reads at the present time (caller sits just after a falling edge)
    task automatic rd_chk(input logic [4:0] a, input string tag);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, model_rd(a));
        check("R7", 32'(irq), 32'(model_irq()));
    endtask

    initial begin
        void'($urandom(32'h1357_9BDF));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values, explicit
        for (int a = 0; a < 32; a++) begin
            bus_addr = 5'(a); #2;
            check("R1", bus_rdata,
                  (a >= 8 && a[2:0] < 3) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("R1", 32'(irq), 0);

        // R2: stopped channel holds; run channel 1 for a known span
        wr(5'h00, 32'h2);
        repeat (6) @(negedge clk);
        wr(5'h00, 32'h0);
        wr(5'h01, 32'h1);
        wr(5'h02, 32'h1);
        // R8: busy window edge by edge
        bus_addr = 5'h03; #2; check("R8 busy after request", bus_rdata, 1);
        bus_addr = 5'h02; #2; check("R9 old capture while busy", bus_rdata, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); bus_addr = 5'h03; #2;
            check("R8 busy held", bus_rdata, 1);
        end
        @(negedge clk); bus_addr = 5'h03; #2; check("R8 busy drops", bus_rdata, 0);
        bus_addr = 5'h02; #2; check("R2/R8 frozen count captured", bus_rdata, 32'd8);

        // R3: step from all ones to zero via reload just below the top
        wr(5'h0B, 32'hFFFF_FFFD);   // ch0 reload value
        wr(5'h08, 32'd4);           // ch0 compare 0
        wr(5'h0C, 32'h1);           // ch0 reload on compare 0
        wr(5'h01, 32'h0);
        wr(5'h00, 32'h1);
        repeat (7) @(negedge clk);
        wr(5'h00, 32'h0);
        wr(5'h02, 32'h1);
        repeat (5) @(negedge clk);
        rd_chk(5'h02, "R3 wrap to zero");
        rd_chk(5'h0D, "R4/R5 status after hits");

        // R6: clear, R7: irq
        wr(5'h0E, 32'h7);
        #2; check("R7 irq with enable", 32'(irq[0]), 32'(|m_stat[0]));
        wr(5'h0F, 32'h7);
        rd_chk(5'h0D, "R6 clear");
        check("R7 irq after clear", 32'(irq[0]), 0);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int op;
            int c;
            op = $urandom_range(0, 9);
            c  = $urandom_range(0, 2);
            if (n % 250 == 249) begin
                @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
            end
            case (op)
                0: wr(5'h00, 32'($urandom_range(0, 7)));
                1: wr(5'((c + 1) * 8 + $urandom_range(0, 2)),
                      ($urandom_range(0, 15) == 0) ? 32'hFFFF_FFFF : 32'($urandom_range(0, 60)));
                2: wr(5'((c + 1) * 8 + 3), 32'($urandom_range(0, 30)));
                3: wr(5'((c + 1) * 8 + 4), 32'($urandom_range(0, 7)));
                4: wr(5'((c + 1) * 8 + 6), 32'($urandom_range(0, 7)));
                5: wr(5'((c + 1) * 8 + 7), 32'($urandom_range(0, 7)));
                6: wr(5'h01, 32'($urandom_range(0, 3)));
                7: wr(5'h02, 32'($urandom_range(0, 3)));
                8: wr(5'($urandom_range(4, 7)), $urandom);
                default: repeat ($urandom_range(0, 5)) @(negedge clk);
            endcase
            begin
                logic [4:0] a;
                a = 5'($urandom_range(0, 31));
                rd_chk(a, tag_of(a));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule